// File: doc/BRIEF.md
# Clock Output Gating and Strap Controller

This block sits between the clock synthesis core and the output drivers of a multi-output system clock generator. For every derived clock output lane it produces a gate enable that decides whether the lane toggles or is held low. It also produces a global tristate request, an output-enable for four dual-role pins, and the 3-bit frequency code handed to the synthesizer.

While power-on reset is asserted, the block samples three kinds of strap pins on the reference clock: the frequency code, the operating mode and the CPU supply select. It holds the sampled values once reset releases. The mode strap gives four shared pins one of two roles. In mobile mode they are active-low stop and power-down inputs. In desktop mode they carry four extra SDRAM clock lanes.

Lanes fall into five classes: CPU, PCI (stoppable), AGP (stoppable), free-running, and shared SDRAM. Each class runs on its own domain clock. A lane's request combines its register enable bit, its class stop, power-down and the mode. The request passes through a synchronizer in the lane's clock domain and is applied at a falling edge, so a lane never produces a shortened high phase.

Top module: `clkgate_strap_ctrl`

## Requirements
- R1: While `por_n` is low, `strap_fs`, `strap_mode` and `strap_vsel` are sampled at every rising edge of `clk_ref`. After `por_n` goes high, later changes on these pins do not change `freq_code` (when not overridden), the mode or `cpu_v25`.
- R2: `freq_code` equals `cfg_fcode` when `cfg_fsel_ovr` is 1, and the strapped frequency code when it is 0.
- R3: The mode strap is 1 for desktop and 0 for mobile. In desktop mode `shr_oe` is 1 and the shared SDRAM lanes follow their enable bits. In mobile mode `shr_oe` is 0 and the shared SDRAM lanes are held at 0.
- R4: In mobile mode, shared input bit 0 (CPU stop), bit 1 (PCI stop) and bit 2 (AGP stop) are active low. Each one holds every lane of its class at 0.
- R5: Free-running lanes are never affected by the CPU, PCI or AGP stop inputs.
- R6: In mobile mode, shared input bit 3 low (power-down) holds every lane at 0, free-running lanes included.
- R7: In desktop mode, the values on `shr_in` have no effect on any lane.
- R8: A `lane_ena` bit of 0 holds its lane at 0. Lane order in `lane_ena` and `gate_en` is CPU lanes from bit 0, then PCI, then AGP, then free-running, then the four shared SDRAM lanes.
- R9: A gate changes only at a falling edge of its domain clock. A request change is taken by `SYNC_STAGES` rising edges and then applied at the next falling edge.
- R10: `outs_hiz` follows `cfg_hiz` (1 = tristate all outputs).
- R11: While `por_n` is low, every `gate_en` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference domain clock: strap sampling and free-running lanes |
| clk_cpu | input | 1 | CPU lane domain clock |
| clk_pci | input | 1 | PCI lane domain clock |
| clk_agp | input | 1 | AGP lane domain clock |
| clk_sdr | input | 1 | Shared SDRAM lane domain clock |
| por_n | input | 1 | Power-on reset, active low |
| strap_fs | input | FW | Frequency-select strap pins |
| strap_mode | input | 1 | Mode strap, 1 desktop, 0 mobile |
| strap_vsel | input | 1 | CPU supply-select strap |
| shr_in | input | 4 | Shared pin input levels: [0] CPU stop, [1] PCI stop, [2] AGP stop, [3] power-down, all active low |
| cfg_fsel_ovr | input | 1 | 1 selects `cfg_fcode` as the frequency code |
| cfg_fcode | input | FW | Register frequency code |
| cfg_hiz | input | 1 | Register request to tristate all outputs |
| lane_ena | input | NL | Per-lane register enable bits |
| gate_en | output | NL | Per-lane clock gate enable |
| freq_code | output | FW | Active frequency code |
| cpu_v25 | output | 1 | Latched CPU supply-select |
| shr_oe | output | 1 | Shared pins drive outputs (desktop mode) |
| outs_hiz | output | 1 | Tristate request for all outputs |

## Verification
The bench builds the block with its default parameters: 3 CPU, 5 PCI, 2 AGP and 4 free-running lanes, a 3-bit code and two synchronizer stages. All five domain clocks are tied to one bench clock. This makes the exact latency of R9 observable as a fixed count of rising edges followed by one falling edge. The bench resets the block twice, once per mode strap value. That brings both roles of the shared pins within reach, along with the ignore behaviour of R7 and the strap hold of R1 under pin changes after release.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

   typedef enum logic [2:0] {
      LC_CPU,
      LC_PCI,
      LC_AGP,
      LC_FREE,
      LC_SHR
   } lane_class_e;

   typedef struct packed {
      logic cpu;
      logic pci;
      logic agp;
      logic pd;
   } stop_t;

   localparam int SHR_PINS = 4;

endpackage

// File: rtl/clkgate_strap_latch.sv
module clkgate_strap_latch #(
   parameter int FW = 3
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic [FW-1:0] fs_pin,
   input  logic          mode_pin,
   input  logic          vsel_pin,
   output logic [FW-1:0] fs_q,
   output logic          desktop_q,
   output logic          v25_q
);

   // transparent sampling during reset, frozen afterwards
   always_ff @(posedge clk) begin
      if (!por_n) begin
         fs_q      <= fs_pin;
         desktop_q <= mode_pin;
         v25_q     <= vsel_pin;
      end
   end

endmodule

// File: rtl/clkgate_pin_decode.sv
module clkgate_pin_decode
   import clkgate_pkg::*;
(
   input  logic                desktop,
   input  logic [SHR_PINS-1:0] shr_in,
   output stop_t               stops,
   output logic                shr_oe
);

   always_comb begin
      stops.cpu = !desktop && !shr_in[0];
      stops.pci = !desktop && !shr_in[1];
      stops.agp = !desktop && !shr_in[2];
      stops.pd  = !desktop && !shr_in[3];
   end

   assign shr_oe = desktop;

endmodule

// File: rtl/clkgate_lane.sv
module clkgate_lane #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic gate
);

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], req};
   end

   // apply on the falling edge so the high phase is never cut
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate <= 1'b0;
      else        gate <= sync_q[SYNC_STAGES-1];
   end

endmodule

// File: rtl/clkgate_strap_ctrl.sv
module clkgate_strap_ctrl
   import clkgate_pkg::*;
#(
   parameter int N_CPU       = 3,
   parameter int N_PCI       = 5,
   parameter int N_AGP       = 2,
   parameter int N_FREE      = 4,
   parameter int FW          = 3,
   parameter int SYNC_STAGES = 2,
   localparam int NL         = N_CPU + N_PCI + N_AGP + N_FREE + SHR_PINS
) (
   input  logic                clk_ref,
   input  logic                clk_cpu,
   input  logic                clk_pci,
   input  logic                clk_agp,
   input  logic                clk_sdr,
   input  logic                por_n,
   input  logic [FW-1:0]       strap_fs,
   input  logic                strap_mode,
   input  logic                strap_vsel,
   input  logic [SHR_PINS-1:0] shr_in,
   input  logic                cfg_fsel_ovr,
   input  logic [FW-1:0]       cfg_fcode,
   input  logic                cfg_hiz,
   input  logic [NL-1:0]       lane_ena,
   output logic [NL-1:0]       gate_en,
   output logic [FW-1:0]       freq_code,
   output logic                cpu_v25,
   output logic                shr_oe,
   output logic                outs_hiz
);

   localparam int OFS_PCI  = N_CPU;
   localparam int OFS_AGP  = OFS_PCI + N_PCI;
   localparam int OFS_FREE = OFS_AGP + N_AGP;
   localparam int OFS_SHR  = OFS_FREE + N_FREE;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (N_CPU < 1 || N_PCI < 1 || N_AGP < 1 || N_FREE < 1) begin : g_bad_cnt
      $error("each lane class needs at least one lane");
   end
   if (FW < 1) begin : g_bad_fw
      $error("FW must be positive");
   end

   function automatic lane_class_e class_of(input int idx);
      if (idx < OFS_PCI)       return LC_CPU;
      else if (idx < OFS_AGP)  return LC_PCI;
      else if (idx < OFS_FREE) return LC_AGP;
      else if (idx < OFS_SHR)  return LC_FREE;
      else                     return LC_SHR;
   endfunction

   logic [FW-1:0] fs_q;
   logic          desktop_q;
   stop_t         stops;

   clkgate_strap_latch #(.FW(FW)) u_straps (
      .clk       (clk_ref),
      .por_n     (por_n),
      .fs_pin    (strap_fs),
      .mode_pin  (strap_mode),
      .vsel_pin  (strap_vsel),
      .fs_q      (fs_q),
      .desktop_q (desktop_q),
      .v25_q     (cpu_v25)
   );

   clkgate_pin_decode u_decode (
      .desktop (desktop_q),
      .shr_in  (shr_in),
      .stops   (stops),
      .shr_oe  (shr_oe)
   );

   for (genvar li = 0; li < NL; li++) begin : g_lane
      localparam lane_class_e LC = class_of(li);
      logic lclk;
      logic lhold;
      logic lreq;

      if (LC == LC_CPU) begin : g_cpu
         assign lclk  = clk_cpu;
         assign lhold = stops.cpu;
      end else if (LC == LC_PCI) begin : g_pci
         assign lclk  = clk_pci;
         assign lhold = stops.pci;
      end else if (LC == LC_AGP) begin : g_agp
         assign lclk  = clk_agp;
         assign lhold = stops.agp;
      end else if (LC == LC_FREE) begin : g_free
         assign lclk  = clk_ref;
         assign lhold = 1'b0;
      end else begin : g_shr
         assign lclk  = clk_sdr;
         assign lhold = !desktop_q;
      end

      assign lreq = lane_ena[li] && !lhold && !stops.pd;

      clkgate_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
         .clk   (lclk),
         .rst_n (por_n),
         .req   (lreq),
         .gate  (gate_en[li])
      );
   end

   assign freq_code = cfg_fsel_ovr ? cfg_fcode : fs_q;
   assign outs_hiz  = cfg_hiz;

endmodule

// File: rtl/clkgate_strap_ctrl_chk.sv
module clkgate_strap_ctrl_chk
   import clkgate_pkg::*;
#(
   parameter int NL          = 18,
   parameter int FW          = 3,
   parameter int OFS_FREE    = 10,
   parameter int N_FREE      = 4,
   parameter int OFS_SHR     = 14,
   parameter int SYNC_STAGES = 2
) (
   input logic                clk_ref,
   input logic                clk_sdr,
   input logic                por_n,
   input logic [FW-1:0]       fs_q,
   input logic                desktop_q,
   input logic                v25_q,
   input stop_t               stops,
   input logic [SHR_PINS-1:0] shr_in,
   input logic [NL-1:0]       gate_en
);

   logic [7:0]        pd_cnt;
   logic [N_FREE-1:0] hi_snap;
   logic              snap_ok;

   always_ff @(posedge clk_ref or negedge por_n) begin
      if (!por_n) pd_cnt <= '0;
      else if (!desktop_q && !shr_in[3]) pd_cnt <= (pd_cnt == 8'hff) ? pd_cnt : pd_cnt + 8'd1;
      else pd_cnt <= '0;
   end

   always_ff @(posedge clk_ref or negedge por_n) begin
      if (!por_n) begin
         hi_snap <= '0;
         snap_ok <= 1'b0;
      end else begin
         hi_snap <= gate_en[OFS_FREE +: N_FREE];
         snap_ok <= 1'b1;
      end
   end

   // R1
   strap_hold_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
      $past(por_n) |-> $stable({fs_q, desktop_q, v25_q}));

   // R7
   desktop_ign_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
      desktop_q |-> (stops == '0));

   // R3
   mobile_shr_low_chk: assert property (@(posedge clk_sdr) disable iff (!por_n)
      !desktop_q |-> (gate_en[OFS_SHR +: SHR_PINS] == '0));

   // R6
   pd_free_low_chk: assert property (@(posedge clk_ref) disable iff (!por_n)
      (int'(pd_cnt) >= SYNC_STAGES + 1) |-> (gate_en[OFS_FREE +: N_FREE] == '0));

   // R9
   always @(negedge clk_ref) begin
      if (por_n && snap_ok) begin
         no_runt_chk: assert (gate_en[OFS_FREE +: N_FREE] == hi_snap);
      end
   end

endmodule

bind clkgate_strap_ctrl clkgate_strap_ctrl_chk #(
   .NL          (NL),
   .FW          (FW),
   .OFS_FREE    (OFS_FREE),
   .N_FREE      (N_FREE),
   .OFS_SHR     (OFS_SHR),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk_ref   (clk_ref),
   .clk_sdr   (clk_sdr),
   .por_n     (por_n),
   .fs_q      (fs_q),
   .desktop_q (desktop_q),
   .v25_q     (cpu_v25),
   .stops     (stops),
   .shr_in    (shr_in),
   .gate_en   (gate_en)
);

// File: tb/clkgate_strap_ctrl_tb.sv
module clkgate_strap_ctrl_tb;

   localparam int N_CPU = 3, N_PCI = 5, N_AGP = 2, N_FREE = 4, FW = 3, SYNC = 2;
   localparam int NL = N_CPU + N_PCI + N_AGP + N_FREE + 4;
   localparam int O_PCI = N_CPU, O_AGP = O_PCI + N_PCI, O_FREE = O_AGP + N_AGP, O_SHR = O_FREE + N_FREE;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic [FW-1:0] strap_fs = '0;
   logic          strap_mode = 1'b0, strap_vsel = 1'b0;
   logic [3:0]    shr_in = 4'hf;
   logic          cfg_fsel_ovr = 1'b0, cfg_hiz = 1'b0;
   logic [FW-1:0] cfg_fcode = '0;
   logic [NL-1:0] lane_ena = '1;
   logic [NL-1:0] gate_en;
   logic [FW-1:0] freq_code;
   logic          cpu_v25, shr_oe, outs_hiz;

   int n_chk = 0, n_bad = 0;
   bit cur_dk = 1'b0;

   always #2 clk = ~clk;

   clkgate_strap_ctrl #(
      .N_CPU(N_CPU), .N_PCI(N_PCI), .N_AGP(N_AGP), .N_FREE(N_FREE), .FW(FW), .SYNC_STAGES(SYNC)
   ) u_dut (
      .clk_ref(clk), .clk_cpu(clk), .clk_pci(clk), .clk_agp(clk), .clk_sdr(clk),
      .por_n(por_n), .strap_fs(strap_fs), .strap_mode(strap_mode), .strap_vsel(strap_vsel),
      .shr_in(shr_in), .cfg_fsel_ovr(cfg_fsel_ovr), .cfg_fcode(cfg_fcode), .cfg_hiz(cfg_hiz),
      .lane_ena(lane_ena), .gate_en(gate_en), .freq_code(freq_code), .cpu_v25(cpu_v25),
      .shr_oe(shr_oe), .outs_hiz(outs_hiz)
   );

   function automatic logic [NL-1:0] model(bit dk, logic [3:0] shr, logic [NL-1:0] ena);
      logic [NL-1:0] v;
      for (int i = 0; i < NL; i++) begin
         v[i] = ena[i];
         if (!dk && !shr[3]) v[i] = 1'b0;
         if (i < O_PCI && !dk && !shr[0]) v[i] = 1'b0;
         if (i >= O_PCI && i < O_AGP && !dk && !shr[1]) v[i] = 1'b0;
         if (i >= O_AGP && i < O_FREE && !dk && !shr[2]) v[i] = 1'b0;
         if (i >= O_SHR && !dk) v[i] = 1'b0;
      end
      return v;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (SYNC + 3) @(posedge clk);
      #1;
   endtask

   task automatic chk_gates(string tag);
      settle();
      chk(tag, 32'(gate_en), 32'(model(cur_dk, shr_in, lane_ena)));
   endtask

   task automatic do_reset(bit dk, logic [FW-1:0] fs, bit vs);
      @(negedge clk);
      por_n = 1'b0; strap_mode = dk; strap_fs = fs; strap_vsel = vs;
      shr_in = 4'hf; lane_ena = '1; cfg_fsel_ovr = 1'b0; cfg_hiz = 1'b0;
      repeat (4) @(posedge clk);
      #1 chk("R11 gates low in reset", 32'(gate_en), 32'h0);
      @(negedge clk);
      por_n = 1'b1; cur_dk = dk;
      strap_fs = ~fs; strap_mode = ~dk; strap_vsel = ~vs;
   endtask

   task automatic t_straps(logic [FW-1:0] fs, bit vs, bit dk);
      settle();
      chk("R1 strap fs held", 32'(freq_code), 32'(fs));
      chk("R1 vsel held", 32'(cpu_v25), 32'(vs));
      chk("R3 shr_oe by mode", 32'(shr_oe), 32'(dk));
   endtask

   task automatic t_override();
      logic [FW-1:0] keep = freq_code;
      cfg_fsel_ovr = 1'b1; cfg_fcode = 3'd5; #1;
      chk("R2 override code", 32'(freq_code), 32'd5);
      cfg_fcode = 3'd2; #1;
      chk("R2 override code 2", 32'(freq_code), 32'd2);
      cfg_fsel_ovr = 1'b0; #1;
      chk("R2 back to strap", 32'(freq_code), 32'(keep));
   endtask

   task automatic t_stops();
      @(negedge clk); shr_in = 4'b1110; chk_gates("R4 cpu stop / R5 free runs");
      chk("R5 free lanes on", 32'(gate_en[O_FREE +: N_FREE]), 32'hf);
      @(negedge clk); shr_in = 4'b1101; chk_gates("R4 pci stop");
      @(negedge clk); shr_in = 4'b1011; chk_gates("R4 agp stop");
      @(negedge clk); shr_in = 4'b1000; chk_gates("R4 all stops / R5");
      chk("R5 free lanes on under stops", 32'(gate_en[O_FREE +: N_FREE]), 32'hf);
      @(negedge clk); shr_in = 4'b0111; chk_gates("R6 power-down");
      chk("R6 all lanes low", 32'(gate_en), 32'h0);
      @(negedge clk); shr_in = 4'hf; chk_gates("R3 mobile resume");
   endtask

   task automatic t_enable();
      @(negedge clk); lane_ena = '1; lane_ena[1] = 1'b0; lane_ena[O_FREE] = 1'b0; lane_ena[O_SHR + 2] = 1'b0;
      chk_gates("R8 enable bits");
      @(negedge clk); lane_ena = '1; chk_gates("R8 enable restore");
   endtask

   task automatic t_latency();
      @(negedge clk); shr_in = 4'hf; settle();
      @(negedge clk); shr_in = 4'b1110;
      repeat (SYNC) @(posedge clk);
      #1 chk("R9 cpu gate not yet changed", 32'(gate_en[N_CPU-1:0]), 32'h7);
      @(negedge clk);
      #1 chk("R9 cpu gate low at falling edge", 32'(gate_en[N_CPU-1:0]), 32'h0);
      @(negedge clk); shr_in = 4'hf; settle();
   endtask

   task automatic t_hiz();
      cfg_hiz = 1'b1; #1 chk("R10 hiz on", 32'(outs_hiz), 32'h1);
      cfg_hiz = 1'b0; #1 chk("R10 hiz off", 32'(outs_hiz), 32'h0);
   endtask

   task automatic t_desktop();
      chk_gates("R3 desktop shared lanes on");
      chk("R3 shared lanes", 32'(gate_en[O_SHR +: 4]), 32'hf);
      @(negedge clk); shr_in = 4'b0000; chk_gates("R7 pins ignored");
      chk("R7 all lanes on", 32'(gate_en), 32'((1 << NL) - 1));
      @(negedge clk); shr_in = 4'b0110; chk_gates("R7 pins ignored 2");
      @(negedge clk); lane_ena[O_SHR] = 1'b0; chk_gates("R8 desktop shared enable");
      @(negedge clk); lane_ena = '1; shr_in = 4'hf;
   endtask

   initial begin
      do_reset(1'b0, 3'd6, 1'b1);
      t_straps(3'd6, 1'b1, 1'b0);
      chk_gates("R3 mobile idle");
      t_override();
      t_stops();
      t_enable();
      t_latency();
      t_hiz();
      do_reset(1'b1, 3'd3, 1'b0);
      t_straps(3'd3, 1'b0, 1'b1);
      t_override();
      t_desktop();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #800000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule